// File: doc/BRIEF.md
# Serial Byte Monitor with Hex Display

This block listens to an asynchronous serial receive line that carries frames at 9600 baud in 8N1 form. Each frame has one start bit at logic 0, eight data bits with the least significant bit first, and one stop bit at logic 1. There is no parity. The block keeps the last byte whose stop bit was valid. It shows that byte as two hexadecimal digits on a four-digit, time-multiplexed seven-segment display.

The receive line passes through a two-stage synchronizer. The receiver then checks the start bit at half a bit time after the falling edge. After that it samples every bit at its centre. A frame whose stop bit reads 0 is discarded.

A scan counter walks the four digit slots in turn. Slot 0, the rightmost digit, shows the low nibble. Slot 1 shows the high nibble. Slots 2 and 3 are kept dark. All display outputs are active low. The clock is 50 MHz by default and the reset is synchronous and active low.

Top module: `serial_hex_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it, the stored byte is 0x00. The scan slot is 0, so `an_n` = 4'b1110 and `seg_n` = 8'h03, the glyph for 0.
- R2: A frame is captured as follows: a falling edge, a start bit that is still 0 at its midpoint, then eight data bits sampled at their centres, least significant bit first, then a stop bit of 1. The data bits become the displayed byte.
- R3: A frame whose stop bit samples as 0 leaves the displayed byte unchanged.
- R4: A low pulse shorter than half a bit period is treated as a glitch. It does not change the displayed byte, and the receiver stays ready for the next frame.
- R5: At most one anode is driven low at any time, and `an_n[3]` and `an_n[2]` are always 1.
- R6: In slot 1 the display shows the high nibble on `an_n[1]`. In slot 0 it shows the low nibble on `an_n[0]`.
- R7: Bit 7 of `seg_n` drives segment a, and bits 6 down to 1 drive b, c, d, e, f and g. Bit 0 drives the decimal point and is always 1. The glyphs, written as active-low `seg_n` values for nibbles 0 to F, are: 03, 9F, 25, 0D, 99, 49, 41, 1F, 01, 09, 11, C1, 63, 85, 61, 71.
- R8: The scan slot starts at 0 after reset. It advances by one every SCAN_DIV clocks in the order 0, 1, 2, 3 and then wraps to 0.
- R9: In slots 2 and 3 every anode is 1 and `seg_n` is 8'hFF.
- R10: A frame whose start edge directly follows the previous stop bit is received correctly.
- R11: Pulling reset low in the middle of operation returns the block to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz by default) |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial receive line, idles at 1 |
| an_n | output | 4 | Digit enables, active low; bit 0 is the rightmost digit |
| seg_n | output | 8 | Segment drives, active low; bit 7 = a, bit 0 = decimal point |

## Verification
Some cases are hard to bring about from the pins: a start glitch that clears before the midpoint check, a stop bit held low, and a start edge that lands right after the stop sample of the previous frame. The bench builds each of these directly on the line with per-clock timing. It runs the block with a 16-clock bit period so that many frames fit in a short run. A behavioural model, built from a cycle count and an expected byte, predicts the anode and segment values on every clock outside a frame. Each of these odd frames is followed by a good frame, so the bench can tell that the receiver came back to idle.

// File: rtl/serial_hex_pkg.sv
// Shared types and the nibble-to-glyph function for the serial hex monitor.
// Assumes a four-slot scan and a seven-segment layout ordered a..g.
package serial_hex_pkg;

    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Active-high segment pattern {a,b,c,d,e,f,g} for one hex nibble.
    function automatic logic [6:0] glyph_of(input logic [3:0] nib);
        logic [6:0] g;
        case (nib)
            4'h0: g = 7'b1111110;
            4'h1: g = 7'b0110000;
            4'h2: g = 7'b1101101;
            4'h3: g = 7'b1111001;
            4'h4: g = 7'b0110011;
            4'h5: g = 7'b1011011;
            4'h6: g = 7'b1011111;
            4'h7: g = 7'b1110000;
            4'h8: g = 7'b1111111;
            4'h9: g = 7'b1111011;
            4'hA: g = 7'b1110111;
            4'hB: g = 7'b0011111;
            4'hC: g = 7'b1001110;
            4'hD: g = 7'b0111101;
            4'hE: g = 7'b1001111;
            default: g = 7'b1000111;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for an asynchronous line that idles high.
// Assumes the input changes far more slowly than the clock.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain; reset to idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/frame_rx.sv
// Receives 8N1-style frames (parameterised data width) from a synchronized line.
// It samples at bit centres and stores the byte only when the stop bit is high.
// Assumes line is already synchronized to clk.
module frame_rx
    import serial_hex_pkg::*;
#(
    parameter int CLKS_PER_BIT = 5208,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line,
    output logic [DATA_BITS-1:0] byte_q
);
    localparam int HALF_BIT = CLKS_PER_BIT / 2;
    localparam int CW       = $clog2(CLKS_PER_BIT);
    localparam int IW       = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    rx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 line_d;
    logic                 fall;

    // Delayed copy of the line, used to find the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 1'b1;
        else        line_d <= line;
    end

    assign fall = line_d & ~line;

    // Frame sequencer: start check at half bit, then sampling at bit centres.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            byte_q <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (fall) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == CW'(HALF_BIT - 1)) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CW'(CLKS_PER_BIT - 1)) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[DATA_BITS-1:1]};
                        if (idx == IW'(DATA_BITS - 1)) state <= RX_STOP;
                        else                           idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(CLKS_PER_BIT - 1)) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                        if (line) byte_q <= shreg;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R3
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_STOP) |=> $stable(byte_q));

    // R4
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !fall) |=> (state == RX_IDLE));

    // R2
    start_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && fall) |=> (state == RX_START && cnt == '0));
endmodule

// File: rtl/hex_scan.sv
// Time-multiplexes a byte onto a four-slot seven-segment display.
// Slot 0 shows the low nibble, slot 1 the high nibble, slots 2-3 stay dark.
// Outputs are active low; bit 0 of the segment bus is the decimal point.
module hex_scan
    import serial_hex_pkg::*;
#(
    parameter int SCAN_DIV = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       value,
    output logic [SLOTS-1:0] an_n,
    output logic [7:0]       seg_n
);
    localparam int DW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int SW = $clog2(SLOTS);

    logic [DW-1:0] div;
    logic [SW-1:0] slot;
    logic [3:0]    nib;

    // Divider and slot pointer: step the slot every SCAN_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div  <= '0;
            slot <= '0;
        end else if (div == DW'(SCAN_DIV - 1)) begin
            div  <= '0;
            slot <= slot + 1'b1;
        end else begin
            div <= div + 1'b1;
        end
    end

    assign nib = slot[0] ? value[7:4] : value[3:0];

    // Anode and segment drive for the current slot; upper slots blanked.
    always_comb begin
        an_n  = '1;
        seg_n = 8'hFF;
        for (int i = 0; i < 2; i++) begin
            if (slot == SW'(i)) begin
                an_n[i] = 1'b0;
                seg_n   = {~glyph_of(nib), 1'b1};
            end
        end
    end

    // R5
    upper_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_n[3:2] == 2'b11);

    // R5
    one_anode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~an_n) <= 1);

    // R7
    dp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_n[0] == 1'b1);

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div != DW'(SCAN_DIV - 1)) |=> $stable(slot));

    // R9
    blank_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_n == 4'b1111) |-> (seg_n == 8'hFF));
endmodule

// File: rtl/serial_hex_monitor.sv
// Top level: synchronizes the serial line, receives frames and shows the
// last good byte on a multiplexed hex display. Synchronous active-low reset.
module serial_hex_monitor #(
    parameter int CLKS_PER_BIT = 5208,
    parameter int SCAN_DIV     = 12500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    output logic [3:0] an_n,
    output logic [7:0] seg_n
);
    logic       rx_sync;
    logic [7:0] shown;

    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (rx_sync)
    );

    frame_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (rx_sync),
        .byte_q (shown)
    );

    hex_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .value (shown),
        .an_n  (an_n),
        .seg_n (seg_n)
    );
endmodule

// File: tb/sim_serial_hex_monitor.sv
module sim_serial_hex_monitor;
    localparam int P    = 16;
    localparam int SCAN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [3:0] an_n;
    logic [7:0] seg_n;

    int   checks = 0;
    int   fails  = 0;
    int   k      = 0;
    bit   cmp_en = 1'b0;
    bit   busy   = 1'b0;
    logic [7:0] expb = 8'h00;

    serial_hex_monitor #(.CLKS_PER_BIT(P), .SCAN_DIV(SCAN)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .an_n(an_n), .seg_n(seg_n)
    );

    always #5 clk = ~clk;

    // Expected active-low pattern per nibble (R7 table)
    function automatic logic [7:0] seg_of(input logic [3:0] n);
        logic [7:0] t [16] = '{8'h03, 8'h9F, 8'h25, 8'h0D, 8'h99, 8'h49, 8'h41, 8'h1F,
                               8'h01, 8'h09, 8'h11, 8'hC1, 8'h63, 8'h85, 8'h61, 8'h71};
        return t[n];
    endfunction

    // Clock edges seen since reset released
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (cmp_en && !busy) begin
            int d;
            logic [3:0] ea;
            logic [7:0] es;
            d  = (k / SCAN) % 4;
            ea = (d == 0) ? 4'b1110 : (d == 1) ? 4'b1101 : 4'b1111;
            es = (d == 0) ? seg_of(expb[3:0]) : (d == 1) ? seg_of(expb[7:4]) : 8'hFF;
            checks++;
            if (an_n !== ea || seg_n !== es) begin
                fails++;
                if (d < 2)
                    $display("FAIL R6 R7 R8 slot=%0d an=%b seg=%h expected an=%b seg=%h", d, an_n, seg_n, ea, es);
                else
                    $display("FAIL R5 R9 R8 slot=%0d an=%b seg=%h expected an=%b seg=%h", d, an_n, seg_n, ea, es);
            end
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input logic stop);
        rx = 1'b0; repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i]; repeat (P) @(negedge clk);
        end
        rx = stop; repeat (P) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic frame(input logic [7:0] b, input logic stop);
        busy = 1'b1;
        send_bits(b, stop);
        repeat (4) @(negedge clk);
        if (stop) expb = b;
        busy = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_an(input logic [3:0] a);
        for (int i = 0; i < 64; i++) begin
            if (an_n === a) break;
            @(negedge clk);
        end
    endtask

    task automatic check_byte(input string req, input logic [7:0] v);
        wait_an(4'b1110);
        check(req, {an_n, seg_n}, {4'b1110, seg_of(v[3:0])});
        wait_an(4'b1101);
        check(req, {an_n, seg_n}, {4'b1101, seg_of(v[7:4])});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {an_n, seg_n}, {4'b1110, 8'h03});
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R8: slot steps exactly after SCAN clocks
        repeat (SCAN - 1) @(negedge clk);
        check("R8", {8'h0, an_n}, {8'h0, 4'b1110});
        @(negedge clk);
        check("R8", {8'h0, an_n}, {8'h0, 4'b1101});
        repeat (20) @(negedge clk);

        // R2: frame capture, LSB first
        frame(8'h53, 1'b1); check_byte("R2", 8'h53);
        frame(8'hA5, 1'b1); check_byte("R2", 8'hA5);
        frame(8'hFF, 1'b1); check_byte("R2", 8'hFF);
        frame(8'h00, 1'b1); check_byte("R2", 8'h00);

        // R7 / R6: all glyphs in both positions
        frame(8'h01, 1'b1); check_byte("R7", 8'h01);
        frame(8'h23, 1'b1); check_byte("R7", 8'h23);
        frame(8'h45, 1'b1); check_byte("R6", 8'h45);
        frame(8'h67, 1'b1); check_byte("R7", 8'h67);
        frame(8'h89, 1'b1); check_byte("R7", 8'h89);
        frame(8'hAB, 1'b1); check_byte("R7", 8'hAB);
        frame(8'hCD, 1'b1); check_byte("R6", 8'hCD);
        frame(8'hEF, 1'b1); check_byte("R7", 8'hEF);

        // R3: bad stop bit leaves byte alone
        frame(8'h5A, 1'b1);
        frame(8'h77, 1'b0);
        repeat (P) @(negedge clk);
        check_byte("R3", 8'h5A);

        // R4: short glitch, then a good frame
        rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1;
        repeat (3 * P) @(negedge clk);
        check_byte("R4", 8'h5A);
        frame(8'h3C, 1'b1); check_byte("R4", 8'h3C);

        // R10: back-to-back frames
        busy = 1'b1;
        send_bits(8'h96, 1'b1);
        send_bits(8'h4E, 1'b1);
        repeat (4) @(negedge clk);
        expb = 8'h4E;
        busy = 1'b0;
        check_byte("R10", 8'h4E);

        // R5, R9: dark slots and dp over a full scan
        for (int i = 0; i < 4 * SCAN; i++) begin
            check("R5", {10'h0, an_n[3:2]}, {10'h0, 2'b11});
            if (an_n == 4'b1111) check("R9", {4'h0, seg_n}, {4'h0, 8'hFF});
            else                 check("R7", {11'h0, seg_n[0]}, {11'h0, 1'b1});
            @(negedge clk);
        end

        // R11: reset in mid-run
        busy = 1'b1;
        rst_n = 1'b0;
        expb = 8'h00;
        @(negedge clk);
        check("R11", {an_n, seg_n}, {4'b1110, 8'h03});
        rst_n = 1'b1;
        busy = 1'b0;
        repeat (2 * SCAN) @(negedge clk);
        check_byte("R11", 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule